// File: doc/BRIEF.md
# Priority-Threshold Interrupt Selector

This block is the arbitration core of a vectored interrupt controller. It takes a vector of active interrupt requests and a four-bit priority for each request. It names the single request that should be serviced next, gives that request's priority, and raises a flag when the pending work is important enough to pass a five-bit masking threshold. The block stores no state of its own apart from an optional pipeline stage. Holding, acknowledging and clearing requests are left to the logic around it.

The priorities arrive on one flat bus, built as 32-bit words that each hold eight four-bit fields. The selection runs as a balanced tree of pairwise comparisons. First, groups of eight requests are reduced to one candidate per group. Then the group winners are reduced to a single winner. A parameter can place a register between these two stages, which gives one cycle of latency. The result is offered both as separate ports and as a single packed 32-bit word that the surrounding controller can return as a status value.

Top module: `irq_prio_select`

## Requirements
- R1: `valid_o` is high exactly when at least one bit of `req_i` is set. When it is high, `index_o` names an active request whose priority is the largest among all active requests.
- R2: When several active requests share the largest priority, the one with the highest index wins.
- R3: With no active request, `valid_o` is low, `index_o` and `prio_o` are zero, and `result_o` is 32'hFFFFFFFF.
- R4: `above_o` is high when some active request has a priority strictly greater than `thresh_i`, with the priority zero-extended to five bits. Otherwise it is low.
- R5: When `thresh_i` is 5'h1F, `above_o` equals "any request active", whatever the priorities are.
- R6: The priority of request n sits in bits [4*(n mod 8)+3 : 4*(n mod 8)] of 32-bit word n/8 of `prio_i`. Word w occupies bits [32w+31 : 32w].
- R7: While `valid_o` is high, `result_o` carries the winner's index in bits [21:16] and its priority in bits [3:0]. All other bits are zero.
- R8: With LATENCY = 0 the outputs follow the inputs combinationally. With LATENCY = 1 the outputs reflect the inputs present at the previous rising clock edge, and while `rst_n` is low they read as the no-request state of R3 with `above_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional pipeline stage |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline stage |
| req_i | input | 64 | Active request vector, one bit per source |
| prio_i | input | 256 | Packed per-source priorities, eight four-bit fields per 32-bit word |
| thresh_i | input | 5 | Masking threshold for the above-threshold flag |
| valid_o | output | 1 | Some request is active |
| index_o | output | 6 | Index of the winning request |
| prio_o | output | 4 | Priority of the winning request |
| above_o | output | 1 | Some active request exceeds the threshold |
| result_o | output | 32 | Packed index and priority, or all ones when idle |

## Verification
The hardest case to reach is a tie at the top priority between requests in different groups of eight. In that case the tie has to survive both the in-group tree and the across-group tree, and with random priorities it almost never happens. The stimulus reaches it on purpose in two ways. It gives every request the same priority, and it draws priorities from narrow random ranges, which forces frequent ties across groups. A linear scan from the highest index down serves as the reference. Threshold cases are set up right at the strict boundary: priority 15 against thresholds 15, 14 and 31, with the all-ones bypass also tried when every priority is zero.

// File: rtl/ips_pkg.sv
`timescale 1ns/1ps
package ips_pkg;
   localparam int IPS_NREQ_DEF   = 64;
   localparam int IPS_PRIO_W_DEF = 4;
   localparam int IPS_THR_W_DEF  = 5;
   localparam int IPS_GROUP_DEF  = 8;
   localparam int IPS_WORD_W     = 32;
   localparam int IPS_IDX_LSB    = 16;

   function automatic bit ips_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ips_merge.sv
`timescale 1ns/1ps
// One comparison node. A candidate is {valid, index, priority}.
// hi_i always holds higher indices than lo_i, so on equal priority it wins.
module ips_merge #(
   parameter int PRIO_W = 4,
   parameter int CW     = 11
) (
   input  logic [CW-1:0] lo_i,
   input  logic [CW-1:0] hi_i,
   output logic [CW-1:0] win_o
);
   logic lo_v, hi_v, take_hi;
   logic [PRIO_W-1:0] lo_p, hi_p;

   assign lo_v = lo_i[CW-1];
   assign hi_v = hi_i[CW-1];
   assign lo_p = lo_i[PRIO_W-1:0];
   assign hi_p = hi_i[PRIO_W-1:0];

   assign take_hi = hi_v && (!lo_v || (hi_p >= lo_p));
   assign win_o   = take_hi ? hi_i : lo_i;
endmodule

// File: rtl/ips_tree.sv
`timescale 1ns/1ps
// Balanced reduction of N candidates, laid out as a heap.
module ips_tree #(
   parameter int N      = 8,
   parameter int PRIO_W = 4,
   parameter int CW     = 11
) (
   input  logic [N*CW-1:0] cand_i,
   output logic [CW-1:0]   win_o
);
   localparam int NODES = 2 * N - 1;

   if (!ips_pkg::ips_is_pow2(N)) begin : g_bad_n
      $error("ips_tree: N must be a power of two");
   end

   if (N == 1) begin : g_single
      assign win_o = cand_i;
   end else begin : g_heap
      logic [CW-1:0] node [NODES];
      for (genvar k = 0; k < N; k++) begin : g_leaf
         assign node[N-1+k] = cand_i[k*CW +: CW];
      end
      for (genvar i = 0; i < N - 1; i++) begin : g_inner
         ips_merge #(.PRIO_W(PRIO_W), .CW(CW)) u_merge (
            .lo_i (node[2*i+1]),
            .hi_i (node[2*i+2]),
            .win_o(node[i])
         );
      end
      assign win_o = node[0];
   end
endmodule

// File: rtl/ips_thresh.sv
`timescale 1ns/1ps
// Per-group activity and strict threshold comparison.
module ips_thresh #(
   parameter int N      = 8,
   parameter int PRIO_W = 4,
   parameter int THR_W  = 5
) (
   input  logic [N-1:0]        req_i,
   input  logic [N*PRIO_W-1:0] prio_i,
   input  logic [THR_W-1:0]    thr_i,
   output logic                any_act_o,
   output logic                any_above_o
);
   logic [N-1:0] over;

   for (genvar k = 0; k < N; k++) begin : g_cmp
      logic [THR_W-1:0] p_ext;
      assign p_ext   = THR_W'(prio_i[k*PRIO_W +: PRIO_W]);
      assign over[k] = req_i[k] && (p_ext > thr_i);
   end

   assign any_act_o   = |req_i;
   assign any_above_o = |over;
endmodule

// File: rtl/irq_prio_select.sv
`timescale 1ns/1ps
module irq_prio_select #(
   parameter int NREQ    = ips_pkg::IPS_NREQ_DEF,
   parameter int PRIO_W  = ips_pkg::IPS_PRIO_W_DEF,
   parameter int THR_W   = ips_pkg::IPS_THR_W_DEF,
   parameter int GROUP   = ips_pkg::IPS_GROUP_DEF,
   parameter int LATENCY = 0,
   parameter int IDX_W   = $clog2(NREQ)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NREQ-1:0]         req_i,
   input  logic [NREQ*PRIO_W-1:0]  prio_i,
   input  logic [THR_W-1:0]        thresh_i,
   output logic                    valid_o,
   output logic [IDX_W-1:0]        index_o,
   output logic [PRIO_W-1:0]       prio_o,
   output logic                    above_o,
   output logic [ips_pkg::IPS_WORD_W-1:0] result_o
);
   localparam int CW    = 1 + IDX_W + PRIO_W;
   localparam int NGRP  = NREQ / GROUP;
   localparam int WW    = ips_pkg::IPS_WORD_W;
   localparam int ILSB  = ips_pkg::IPS_IDX_LSB;

   // elaboration-time parameter checks
   if (!ips_pkg::ips_is_pow2(NREQ) || !ips_pkg::ips_is_pow2(GROUP) || GROUP > NREQ) begin : g_bad_geom
      $error("irq_prio_select: NREQ and GROUP must be powers of two, GROUP <= NREQ");
   end
   if (LATENCY != 0 && LATENCY != 1) begin : g_bad_lat
      $error("irq_prio_select: LATENCY must be 0 or 1");
   end
   if (THR_W < PRIO_W) begin : g_bad_thr
      $error("irq_prio_select: THR_W must be at least PRIO_W");
   end
   if (PRIO_W > ILSB || ILSB + IDX_W > WW || IDX_W != $clog2(NREQ)) begin : g_bad_pack
      $error("irq_prio_select: index or priority does not fit the packed word");
   end

   // leaf candidates {valid, index, priority}
   logic [NREQ*CW-1:0] leaf;
   for (genvar n = 0; n < NREQ; n++) begin : g_leaf
      assign leaf[n*CW +: CW] = {req_i[n], IDX_W'(n), prio_i[n*PRIO_W +: PRIO_W]};
   end

   // stage 1: reduce each group
   logic [NGRP*CW-1:0] grp_win;
   logic [NGRP-1:0]    grp_act, grp_above;
   logic               thr_all;
   assign thr_all = &thresh_i;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      ips_tree #(.N(GROUP), .PRIO_W(PRIO_W), .CW(CW)) u_tree (
         .cand_i(leaf[g*GROUP*CW +: GROUP*CW]),
         .win_o (grp_win[g*CW +: CW])
      );
      ips_thresh #(.N(GROUP), .PRIO_W(PRIO_W), .THR_W(THR_W)) u_thr (
         .req_i      (req_i[g*GROUP +: GROUP]),
         .prio_i     (prio_i[g*GROUP*PRIO_W +: GROUP*PRIO_W]),
         .thr_i      (thresh_i),
         .any_act_o  (grp_act[g]),
         .any_above_o(grp_above[g])
      );
   end

   // optional stage register
   logic [NGRP*CW-1:0] grp_win_s;
   logic [NGRP-1:0]    grp_act_s, grp_above_s;
   logic               thr_all_s;

   if (LATENCY == 1) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            grp_win_s   <= '0;
            grp_act_s   <= '0;
            grp_above_s <= '0;
            thr_all_s   <= 1'b0;
         end else begin
            grp_win_s   <= grp_win;
            grp_act_s   <= grp_act;
            grp_above_s <= grp_above;
            thr_all_s   <= thr_all;
         end
      end
   end else begin : g_comb
      assign grp_win_s   = grp_win;
      assign grp_act_s   = grp_act;
      assign grp_above_s = grp_above;
      assign thr_all_s   = thr_all;
   end

   // stage 2: reduce the group winners
   logic [CW-1:0] win;
   ips_tree #(.N(NGRP), .PRIO_W(PRIO_W), .CW(CW)) u_final (
      .cand_i(grp_win_s),
      .win_o (win)
   );

   logic              win_v;
   logic [IDX_W-1:0]  win_i;
   logic [PRIO_W-1:0] win_p;
   assign win_v = win[CW-1];
   assign win_i = win[PRIO_W +: IDX_W];
   assign win_p = win[PRIO_W-1:0];

   assign valid_o = win_v;
   assign index_o = win_v ? win_i : '0;
   assign prio_o  = win_v ? win_p : '0;
   assign above_o = thr_all_s ? (|grp_act_s) : (|grp_above_s);

   always_comb begin
      if (win_v) begin
         result_o                  = '0;
         result_o[ILSB +: IDX_W]   = win_i;
         result_o[PRIO_W-1:0]      = win_p;
      end else begin
         result_o = '1;
      end
   end
endmodule

// File: rtl/ips_checker.sv
`timescale 1ns/1ps
module ips_checker #(
   parameter int NREQ    = 64,
   parameter int PRIO_W  = 4,
   parameter int THR_W   = 5,
   parameter int IDX_W   = 6,
   parameter int LATENCY = 0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NREQ-1:0]        req_i,
   input logic [NREQ*PRIO_W-1:0] prio_i,
   input logic [THR_W-1:0]       thresh_i,
   input logic                   valid_o,
   input logic [IDX_W-1:0]       index_o,
   input logic [PRIO_W-1:0]      prio_o,
   input logic                   above_o,
   input logic [31:0]            result_o
);
   logic [NREQ-1:0]        req_c;
   logic [NREQ*PRIO_W-1:0] prio_c;
   logic [THR_W-1:0]       thr_c;

   if (LATENCY == 1) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            req_c  <= '0;
            prio_c <= '0;
            thr_c  <= '0;
         end else begin
            req_c  <= req_i;
            prio_c <= prio_i;
            thr_c  <= thresh_i;
         end
      end
   end else begin : g_live
      assign req_c  = req_i;
      assign prio_c = prio_i;
      assign thr_c  = thresh_i;
   end

   p_valid_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o == (|req_c));
   p_winner_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> req_c[index_o]);
   p_winner_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (prio_o == prio_c[index_o*PRIO_W +: PRIO_W]));
   p_idle_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (result_o == 32'hFFFF_FFFF && index_o == '0 && prio_o == '0));
   p_packed_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (result_o == ((32'(index_o) << 16) | 32'(prio_o))));
   p_no_req_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_c) |-> !above_o);
   p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&thr_c) |-> (above_o == (|req_c)));
endmodule

bind irq_prio_select ips_checker #(
   .NREQ(NREQ), .PRIO_W(PRIO_W), .THR_W(THR_W), .IDX_W(IDX_W), .LATENCY(LATENCY)
) u_ips_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i), .thresh_i(thresh_i),
   .valid_o(valid_o), .index_o(index_o), .prio_o(prio_o), .above_o(above_o),
   .result_o(result_o)
);

// File: tb/irq_prio_select_tb_top.sv
`timescale 1ns/1ps
module irq_prio_select_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  req = '0;
   logic [255:0] prio = '0;
   logic [4:0]   thr = '0;

   logic        v1, v0, a1, a0;
   logic [5:0]  i1, i0;
   logic [3:0]  p1, p0;
   logic [31:0] w1, w0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // expected values of the previous vector (for the registered instance)
   bit        pv_v = 0, pv_a = 0;
   int        pv_i = 0, pv_p = 0;
   logic [31:0] pv_w = 32'hFFFF_FFFF;

   always #4 clk = ~clk;   // 125 MHz

   irq_prio_select #(.LATENCY(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .thresh_i(thr),
      .valid_o(v1), .index_o(i1), .prio_o(p1), .above_o(a1), .result_o(w1));

   irq_prio_select #(.LATENCY(0)) dut_comb_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .thresh_i(thr),
      .valid_o(v0), .index_o(i0), .prio_o(p0), .above_o(a0), .result_o(w0));

   task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   // linear scan from the top index down; strict '>' keeps the highest index on ties
   task automatic ref_eval(input logic [63:0] r, input logic [255:0] p, input logic [4:0] t,
                           output bit v, output int idx, output int pr, output bit ab,
                           output logic [31:0] w);
      int best = -1;
      v = 0; idx = 0; ab = 0;
      for (int n = 63; n >= 0; n--) begin
         if (r[n]) begin
            int pn = int'(p[32*(n/8) + 4*(n%8) +: 4]);
            if (pn > best) begin best = pn; idx = n; v = 1; end
            if (t == 5'h1F || pn > int'(t)) ab = 1;
         end
      end
      pr = v ? best : 0;
      w  = v ? ((32'(idx) << 16) | 32'(pr)) : 32'hFFFF_FFFF;
   endtask

   task automatic cmp_set(input string tag, input string who, input logic v, input logic [5:0] i,
                          input logic [3:0] p, input logic a, input logic [31:0] w,
                          input bit ev, input int ei, input int ep, input bit ea, input logic [31:0] ew);
      chk(tag, {who, " valid"}, 64'(v), 64'(ev));
      chk(tag, {who, " index"}, 64'(i), 64'(ei));
      chk(tag, {who, " prio"},  64'(p), 64'(ep));
      chk(tag, {who, " above"}, 64'(a), 64'(ea));
      chk(tag, {who, " word"},  64'(w), 64'(ew));
   endtask

   task automatic apply(input string tag, input logic [63:0] r, input logic [255:0] p, input logic [4:0] t);
      bit ev, ea; int ei, ep; logic [31:0] ew;
      ref_eval(r, p, t, ev, ei, ep, ea, ew);
      @(negedge clk);
      req = r; prio = p; thr = t;
      #1;
      cmp_set(tag, "comb", v0, i0, p0, a0, w0, ev, ei, ep, ea, ew);
      cmp_set("R8", "pipe-old", v1, i1, p1, a1, w1, pv_v, pv_i, pv_p, pv_a, pv_w);
      @(negedge clk);
      cmp_set(tag, "comb", v0, i0, p0, a0, w0, ev, ei, ep, ea, ew);
      cmp_set(tag, "pipe", v1, i1, p1, a1, w1, ev, ei, ep, ea, ew);
      pv_v = ev; pv_i = ei; pv_p = ep; pv_a = ea; pv_w = ew;
   endtask

   function automatic logic [255:0] all_prio(input logic [3:0] val);
      logic [255:0] x;
      for (int n = 0; n < 64; n++) x[4*n +: 4] = val;
      return x;
   endfunction

   function automatic logic [255:0] rand_prio(input int lo, input int hi);
      logic [255:0] x;
      for (int n = 0; n < 64; n++) x[4*n +: 4] = 4'($urandom_range(hi, lo));
      return x;
   endfunction

   initial begin
      logic [255:0] pp;
      // R8: reset state of the registered instance with every request active
      req = '1; prio = all_prio(4'd9); thr = 5'd0;
      repeat (3) @(negedge clk);
      chk("R8", "reset valid", 64'(v1), 64'd0);
      chk("R8", "reset word", 64'(w1), 64'hFFFF_FFFF);
      chk("R8", "reset above", 64'(a1), 64'd0);
      req = '0; prio = '0; rst_n = 1'b1;

      // R3: idle under several thresholds
      apply("R3", 64'd0, all_prio(4'hF), 5'd0);
      apply("R3", 64'd0, all_prio(4'hF), 5'h1F);

      // R6: single requests at field boundaries of the word layout
      for (int n = 0; n < 64; n += 9) begin
         pp = '0;
         pp[32*(n/8) + 4*(n%8) +: 4] = 4'((n % 15) + 1);
         apply("R6", 64'd1 << n, pp, 5'd0);
      end
      pp = '0; pp[255:252] = 4'd7;
      apply("R6", 64'd1 << 63, pp, 5'd6);

      // R2: ties, every request equal, and subsets straddling groups
      apply("R2", '1, all_prio(4'd5), 5'd0);
      apply("R2", 64'h0000_0001_0000_0100, all_prio(4'd3), 5'd2);
      apply("R2", 64'h8000_0000_0000_0001, all_prio(4'd0), 5'd0);
      for (int k = 0; k < 40; k++)
         apply("R2", {$urandom, $urandom}, all_prio(4'($urandom_range(15, 0))), 5'($urandom_range(31, 0)));

      // R4: strict comparison at the boundary
      apply("R4", 64'd1 << 20, all_prio(4'hF), 5'd15);
      apply("R4", 64'd1 << 20, all_prio(4'hF), 5'd14);
      apply("R4", 64'd1 << 20, all_prio(4'd0), 5'd0);

      // R5: all-ones threshold bypass
      apply("R5", 64'd1 << 33, all_prio(4'd0), 5'h1F);
      apply("R5", '1, all_prio(4'hF), 5'h1F);

      // R1/R7: random vectors, narrow priority ranges force cross-group ties
      for (int k = 0; k < 300; k++) begin
         int hi = (k % 3 == 0) ? 15 : ((k % 3 == 1) ? 2 : 1);
         int lo = (k % 3 == 2) ? 0 : 0;
         apply("R1/R7", {$urandom, $urandom} & {$urandom, $urandom},
               rand_prio(lo, hi), 5'($urandom_range(31, 0)));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule